// File: doc/BRIEF.md
# Two-Level SMI Status and Power-Down Control Register

This block is a single 32-bit control and status register reached over a simple synchronous register bus. It watches two event sources, a serial-interrupt event and a low-pin-count bus error, and turns either one into a system-management interrupt request when that source is enabled. Each source keeps its own sticky second-level status bit. A flag records that a bus error arrived while the bus-error status was already pending. One shared top-level status bit, which is also the interrupt request output, is set by either source. It is cleared by software only when the write-one-to-clear leaves no second-level status pending.

The same register steers a power-down output, which is active low (1 = normal power). Normally the output follows a level from external power-management logic. Software can take it over with an override enable and an override value. The current pin level can always be read back in the register.

Software acknowledges events by writing 1 to the status bits. Writing 0 leaves them alone. Reads return the register image one clock after the read strobe.

Top module: `smi_pd_csr`

## Requirements
- R1: After a synchronous reset the register reads 0x00000080, the power-down output `pd_n_o` is 1 (normal power) and `smi_o` is 0.
- R2: Bit 11 (override enable) and bit 10 (override value) are read/write. While bit 11 is 0, `pd_n_o` follows `pm_pwr_ok` with one clock of delay. While bit 11 is 1, it follows bit 10 (0 = power down, 1 = normal) and ignores `pm_pwr_ok`.
- R3: Bit 7 is read-only and returns the level currently driven on `pd_n_o`.
- R4: Bit 9 (serial-IRQ SMI enable) and bit 8 (bus-error SMI enable) are read/write. An event whose enable is 0 sets no status bit and does not raise `smi_o`.
- R5: An event pulse whose enable is 1 sets the status bit of its source on the next clock edge, and sets the top-level status. The status bit is bit 6 for a serial-IRQ event and bit 5 for a bus error. `smi_o` is 1 whenever the top-level status is set.
- R6: Bits 6, 5 and 4 are cleared by writing 1 to them. Writing 0 to them has no effect.
- R7: Writing 1 to one source status bit clears the top-level status only if the other source status bit is 0, or is cleared by the same write. Otherwise `smi_o` stays 1.
- R8: Bit 4 (multiple-error flag) is set when a bus-error pulse arrives while bit 5 is already 1.
- R9: When an event and a write of 1 to its status bit occur in the same cycle, the event wins. The bit stays 1 and the top-level status stays set.
- R10: Bits 31:12 and 3:0 read as 0. Writes to them, to bit 7, and to any bus address other than the register's own address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data; 0 when not reading this register |
| serirq_evt | input | 1 | Serial-IRQ event pulse, one cycle wide |
| lpc_err_evt | input | 1 | Bus-error event pulse, one cycle wide |
| pm_pwr_ok | input | 1 | Power-down level from power-management logic (1 = normal) |
| pd_n_o | output | 1 | Registered power-down output, active low |
| smi_o | output | 1 | Top-level SMI status, used as the interrupt request |

## Verification
The assertions assume that both event inputs are single-cycle pulses that are synchronous to `clk`, and that `pm_pwr_ok` and the bus signals change only between clock edges. The bench drives every input on the falling edge. Each event is held for exactly one cycle, and bus strobes last one cycle each. Same-cycle collisions, such as an event together with a clearing write, are built on purpose by driving both in one falling-edge slot. This keeps the stimulus inside those assumptions.

// File: rtl/smi_pd_pkg.sv
package smi_pd_pkg;
  // Register field positions (software decodes these).
  localparam int BIT_OVR_EN  = 11;
  localparam int BIT_OVR_VAL = 10;
  localparam int BIT_EN_BASE = 8;   // enable for source i at BIT_EN_BASE+i
  localparam int BIT_PD_PIN  = 7;
  localparam int BIT_STS_BASE = 5;  // status for source i at BIT_STS_BASE+i
  localparam int BIT_MULTI   = 4;

  // Source indices: 0 = bus error, 1 = serial IRQ.
  localparam int NSRC    = 2;
  localparam int SRC_LPC = 0;
  localparam int SRC_SER = 1;

  typedef struct packed {
    logic            ovr_en;
    logic            ovr_val;
    logic [NSRC-1:0] smi_en;
  } ctrl_t;
endpackage

// File: rtl/smi_ctrl_reg.sv
module smi_ctrl_reg
  import smi_pd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_hit) begin
      ctrl.ovr_en  <= wdata[BIT_OVR_EN];
      ctrl.ovr_val <= wdata[BIT_OVR_VAL];
      ctrl.smi_en  <= wdata[BIT_EN_BASE +: NSRC];
    end
  end
endmodule

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // Set has priority over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/smi_top_status.sv
module smi_top_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_set,
  input  logic [N-1:0] src_w1c,
  input  logic [N-1:0] src_sts,
  output logic         top
);
  logic clr;

  // Clear when some source is acknowledged and every other source is
  // either idle or acknowledged by the same write.
  always_comb begin
    clr = 1'b0;
    for (int i = 0; i < N; i++) begin : g_try
      logic others_idle;
      others_idle = 1'b1;
      for (int j = 0; j < N; j++) begin
        if (j != i && src_sts[j] && !src_w1c[j]) others_idle = 1'b0;
      end
      if (src_w1c[i] && others_idle) clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           top <= 1'b0;
    else if (|src_set) top <= 1'b1;
    else if (clr)      top <= 1'b0;
  end
endmodule

// File: rtl/smi_pd_mux.sv
module smi_pd_mux (
  input  logic clk,
  input  logic rst,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic pm_level,
  output logic pd_n
);
  always_ff @(posedge clk) begin
    if (rst) pd_n <= 1'b1;
    else     pd_n <= ovr_en ? ovr_val : pm_level;
  end
endmodule

// File: rtl/smi_pd_csr.sv
module smi_pd_csr
  import smi_pd_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              serirq_evt,
  input  logic              lpc_err_evt,
  input  logic              pm_pwr_ok,
  output logic              pd_n_o,
  output logic              smi_o
);
  logic            wr_hit, rd_hit;
  ctrl_t           ctrl_q;
  logic [NSRC-1:0] evt_in, src_set, src_w1c, src_sts;
  logic            multi_q, multi_set, multi_clr;
  logic [DATA_W-1:0] image;
  logic            unused_wbits;

  assign wr_hit = bus_wr && (bus_addr == REG_ADDR);
  assign rd_hit = bus_rd && (bus_addr == REG_ADDR);
  assign unused_wbits = ^{bus_wdata[DATA_W-1:12], bus_wdata[BIT_PD_PIN], bus_wdata[3:0]};

  assign evt_in[SRC_LPC] = lpc_err_evt;
  assign evt_in[SRC_SER] = serirq_evt;

  smi_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(bus_wdata), .ctrl(ctrl_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_set[s] = evt_in[s] && ctrl_q.smi_en[s];
    assign src_w1c[s] = wr_hit && bus_wdata[BIT_STS_BASE+s];
    smi_sticky_bit u_sts (
      .clk(clk), .rst(rst), .set(src_set[s]), .clr(src_w1c[s]), .q(src_sts[s])
    );
  end

  assign multi_set = lpc_err_evt && src_sts[SRC_LPC];
  assign multi_clr = wr_hit && bus_wdata[BIT_MULTI];
  smi_sticky_bit u_multi (
    .clk(clk), .rst(rst), .set(multi_set), .clr(multi_clr), .q(multi_q)
  );

  smi_top_status #(.N(NSRC)) u_top (
    .clk(clk), .rst(rst), .src_set(src_set), .src_w1c(src_w1c),
    .src_sts(src_sts), .top(smi_o)
  );

  smi_pd_mux u_pd (
    .clk(clk), .rst(rst), .ovr_en(ctrl_q.ovr_en), .ovr_val(ctrl_q.ovr_val),
    .pm_level(pm_pwr_ok), .pd_n(pd_n_o)
  );

  always_comb begin
    image = '0;
    image[BIT_OVR_EN]  = ctrl_q.ovr_en;
    image[BIT_OVR_VAL] = ctrl_q.ovr_val;
    image[BIT_PD_PIN]  = pd_n_o;
    image[BIT_MULTI]   = multi_q;
    for (int s = 0; s < NSRC; s++) begin
      image[BIT_EN_BASE+s]  = ctrl_q.smi_en[s];
      image[BIT_STS_BASE+s] = src_sts[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= image;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/smi_pd_csr_chk.sv
module smi_pd_csr_chk #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              serirq_evt,
  input logic              lpc_err_evt,
  input logic              pm_pwr_ok,
  input logic              pd_n_o,
  input logic              smi_o,
  input logic              ovr_en,
  input logic              en_lpc,
  input logic              sts_lpc,
  input logic              sts_ser,
  input logic              multi
);
  logic hit_w, hit_r;
  assign hit_w = bus_wr && (bus_addr == REG_ADDR);
  assign hit_r = bus_rd && (bus_addr == REG_ADDR);

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (pd_n_o && !smi_o && bus_rdata == '0));

  a_r2_pd_follows_pm: assert property (@(posedge clk) disable iff (rst)
    !ovr_en |=> (pd_n_o == $past(pm_pwr_ok)));

  a_r3_pin_readback: assert property (@(posedge clk) disable iff (rst)
    hit_r |=> (bus_rdata[7] == $past(pd_n_o)));

  a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
    (!sts_lpc && !(lpc_err_evt && en_lpc)) |=> !sts_lpc);

  a_r5_lpc_sets_top: assert property (@(posedge clk) disable iff (rst)
    (lpc_err_evt && en_lpc) |=> (sts_lpc && smi_o));

  a_r6_multi_w1c: assert property (@(posedge clk) disable iff (rst)
    (hit_w && bus_wdata[4] && !lpc_err_evt) |=> !multi);

  a_r7_top_covers_sources: assert property (@(posedge clk) disable iff (rst)
    (sts_lpc || sts_ser) |-> smi_o);

  a_r8_multi_set: assert property (@(posedge clk) disable iff (rst)
    (lpc_err_evt && sts_lpc) |=> multi);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:12] == '0) && (bus_rdata[3:0] == 4'h0));
endmodule

bind smi_pd_csr smi_pd_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .serirq_evt(serirq_evt),
  .lpc_err_evt(lpc_err_evt), .pm_pwr_ok(pm_pwr_ok), .pd_n_o(pd_n_o),
  .smi_o(smi_o), .ovr_en(ctrl_q.ovr_en), .en_lpc(ctrl_q.smi_en[0]),
  .sts_lpc(src_sts[0]), .sts_ser(src_sts[1]), .multi(multi_q)
);

// File: tb/test_smi_pd_csr.sv
`timescale 1ns/1ps
module test_smi_pd_csr;
  localparam logic [7:0] RA = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = RA;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        serirq_evt = 1'b0, lpc_err_evt = 1'b0, pm_pwr_ok = 1'b1;
  logic        pd_n_o, smi_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smi_pd_csr i_smi_pd_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .serirq_evt(serirq_evt),
    .lpc_err_evt(lpc_err_evt), .pm_pwr_ok(pm_pwr_ok), .pd_n_o(pd_n_o), .smi_o(smi_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_evt(logic [7:0] a, logic [31:0] d, logic ser, logic lpc, logic dowr);
    bus_addr = a; bus_wdata = d; bus_wr = dowr;
    serirq_evt = ser; lpc_err_evt = lpc;
    tick();
    bus_wr = 1'b0; serirq_evt = 1'b0; lpc_err_evt = 1'b0; bus_addr = RA;
    tick();
  endtask

  task automatic wr(logic [31:0] d);
    wr_evt(RA, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic pulse(logic ser, logic lpc);
    wr_evt(RA, 32'h0, ser, lpc, 1'b0);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0; bus_addr = RA;
    d = bus_rdata;
  endtask

  task automatic expect_reg(string tag, logic [31:0] exp);
    logic [31:0] v;
    rd(RA, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 reset image", 32'h80);
    chk("R1 reset pd_n_o", {31'b0, pd_n_o}, 32'h1);
    chk("R1 reset smi_o", {31'b0, smi_o}, 32'h0);
  endtask

  task automatic t_override();
    wr(32'hC00);
    expect_reg("R2 override normal image", 32'hC80);
    chk("R2 override normal pd", {31'b0, pd_n_o}, 32'h1);
    wr(32'h800);
    chk("R2 override powerdown pd", {31'b0, pd_n_o}, 32'h0);
    expect_reg("R3 pin readback low", 32'h800);
    pm_pwr_ok = 1'b0; tick(); tick();
    pm_pwr_ok = 1'b1; tick(); tick();
    chk("R2 pm ignored under override", {31'b0, pd_n_o}, 32'h0);
    wr(32'h000);
    chk("R2 follow pm high", {31'b0, pd_n_o}, 32'h1);
    pm_pwr_ok = 1'b0; tick(); tick();
    chk("R2 follow pm low", {31'b0, pd_n_o}, 32'h0);
    expect_reg("R3 pin readback pm low", 32'h000);
    pm_pwr_ok = 1'b1; tick(); tick();
  endtask

  task automatic t_disabled();
    pulse(1'b1, 1'b1);
    expect_reg("R4 disabled events no status", 32'h80);
    chk("R4 disabled smi_o", {31'b0, smi_o}, 32'h0);
    wr(32'h300);
    expect_reg("R4 enables readback", 32'h380);
  endtask

  task automatic t_set_and_top();
    pulse(1'b1, 1'b0);
    expect_reg("R5 serirq status", 32'h3C0);
    chk("R5 smi_o raised", {31'b0, smi_o}, 32'h1);
    pulse(1'b0, 1'b1);
    expect_reg("R5 both status", 32'h3E0);
    wr(32'h300);
    expect_reg("R6 write zero keeps status", 32'h3E0);
    wr(32'h340);
    expect_reg("R6 clear serirq status", 32'h3A0);
    chk("R7 top held while bus-error pending", {31'b0, smi_o}, 32'h1);
    wr(32'h320);
    expect_reg("R7 last clear image", 32'h380);
    chk("R7 top cleared", {31'b0, smi_o}, 32'h0);
  endtask

  task automatic t_both_clear();
    pulse(1'b1, 1'b1);
    expect_reg("R5 both at once", 32'h3E0);
    wr(32'h360);
    expect_reg("R7 joint clear image", 32'h380);
    chk("R7 joint clear top", {31'b0, smi_o}, 32'h0);
  endtask

  task automatic t_multi();
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    expect_reg("R8 multi flag set", 32'h3B0);
    wr(32'h310);
    expect_reg("R6 multi cleared", 32'h3A0);
    chk("R7 top kept after multi clear", {31'b0, smi_o}, 32'h1);
    wr(32'h320);
    expect_reg("R6 bus-error cleared", 32'h380);
  endtask

  task automatic t_collision();
    pulse(1'b0, 1'b1);
    wr_evt(RA, 32'h320, 1'b0, 1'b1, 1'b1);
    expect_reg("R9 event beats clear", 32'h3B0);
    chk("R9 top kept", {31'b0, smi_o}, 32'h1);
    wr_evt(RA, 32'h330, 1'b1, 1'b0, 1'b1);
    expect_reg("R9 other source during clear", 32'h3C0);
    chk("R9 top kept by new source", {31'b0, smi_o}, 32'h1);
    wr(32'h340);
    chk("R9 top finally cleared", {31'b0, smi_o}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(32'hFFFF_F0FF);
    expect_reg("R10 reserved and read-only bits", 32'h80);
    wr_evt(8'h00, 32'h0000_0F00, 1'b0, 1'b0, 1'b1);
    expect_reg("R10 other address write ignored", 32'h80);
    chk("R10 pd unchanged", {31'b0, pd_n_o}, 32'h1);
    rd(8'h04, v);
    chk("R10 other address reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_override();
    t_disabled();
    t_set_and_top();
    t_both_clear();
    t_multi();
    t_collision();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule